// File: doc/BRIEF.md
# Multi-Port Storage Host Register Front End

This block is the register-access front end of a storage host controller that serves a variable number of device ports. A simple 32-bit request/response bus reaches two regions. The first is a small global group that holds capability, control, pending-interrupt, implemented-ports and version words. The second is a row of equal per-port windows. Each port window holds an interrupt status register, an interrupt mask and a scratch word. Hardware events set bits in a port's interrupt status.

The number of live ports is an input, `cfg_ports`, and it can change while the block runs. It sets how far the port region reaches on the bus. It also sets the port-count field of the capability word and the implemented-ports mask. Ports at or above this count are held cleared. Every cycle the block collects the masked status of each live port into a pending vector. It drives one interrupt line when that vector is nonzero and the global interrupt enable is on.

Top module: `mp_hostreg`

## Requirements
- R1: A read of global offset 0x00 returns the capability word. Bits [4:0] hold `cfg_ports`-1 and bits [12:8] hold 31. Bits [23:20] hold 1, and bits 30 and 18 are set. Every other bit is zero, so with 6 ports the word is 0x40141F05.
- R2: Global offset 0x0C reads as a mask with the low `cfg_ports` bits set (all ones for 32 ports). Global offset 0x10 reads 0x00010000.
- R3: Port i owns the bytes from 0x100+i*0x80 to 0x17F+i*0x80. Inside the window, offset 0x00 is interrupt status, 0x04 is interrupt mask and 0x08 is scratch. Status and mask are STAT_W bits wide and are zero-extended on read. `cfg_ports` must stay between 1 and MAX_PORTS.
- R4: The following read as zero, and writes to them change nothing: addresses from 0x100+`cfg_ports`*0x80 upward, global addresses 0x14 to 0xFF, and port offsets other than 0x00, 0x04 and 0x08. Writes to global offsets 0x00, 0x08, 0x0C and 0x10 are also ignored.
- R5: Writing a one to a status bit clears that bit. An event bit on `port_evt` sets the status bit in the same cycle and wins over a clear.
- R6: Bit i of `irq_pending` and of global offset 0x08 is set one clock after a cycle in which port i was live and its status AND mask was nonzero.
- R7: Global offset 0x04 stores only bit 1, the interrupt enable, and reads it back in place. `irq_out` is high when the pending vector is nonzero and the enable is set.
- R8: A read accepted at a clock edge returns its data on `rsp_rdata`, with `rsp_valid` high, in the following cycle. Writes produce no response.
- R9: Reset clears the enable, the pending vector, the response and every port's status, mask and scratch.
- R10: A port at index `cfg_ports` or above is cleared at every clock. It ignores its events and never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ports | input | CNT_W (6) | Number of live ports, 1 to MAX_PORTS |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (13) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| port_evt | input | MAX_PORTS*STAT_W | Per-port status set pulses, port i at bits [i*STAT_W +: STAT_W] |
| irq_pending | output | MAX_PORTS | Registered per-port pending vector |
| irq_out | output | 1 | Combined interrupt line |

## Verification
Read data and `rsp_valid` are due one edge after the request. `irq_pending` is due one edge after the cycle whose status and mask it reflects. `irq_out` follows that edge combinationally, using the enable as written at the same edge. The bench drives inputs at the falling edge and computes every expected value from its model as it stood before the next rising edge. It then updates the model for that edge and compares at the following falling edge, so each result is sampled exactly one register stage after its cause.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
   localparam int unsigned DATA_W     = 32;
   localparam int unsigned PORT_BASE  = 32'h100;
   localparam int unsigned PORT_SHIFT = 7;
   localparam int unsigned GLOB_LIMIT = 32'h20;

   localparam logic [6:0] G_CAP  = 7'h00;
   localparam logic [6:0] G_HCTL = 7'h04;
   localparam logic [6:0] G_PEND = 7'h08;
   localparam logic [6:0] G_PIMP = 7'h0C;
   localparam logic [6:0] G_VER  = 7'h10;

   localparam logic [6:0] P_STAT = 7'h00;
   localparam logic [6:0] P_MASK = 7'h04;
   localparam logic [6:0] P_SCR  = 7'h08;

   localparam int unsigned IEN_BIT  = 1;
   localparam logic [31:0] VER_CODE = 32'h0001_0000;
   // slots field 31, gen-1 speed, queuing flag, native-only flag
   localparam logic [31:0] CAP_FIXED = 32'h4014_1F00;

   function automatic logic [31:0] cap_word(input int n);
      logic [31:0] cnt;
      cnt = 32'(n - 1);
      return CAP_FIXED | {27'd0, cnt[4:0]};
   endfunction

   function automatic logic [31:0] pimp_word(input int n);
      logic [32:0] full;
      full = (33'd1 << n) - 33'd1;
      return full[31:0];
   endfunction
endpackage

// File: rtl/hreg_addr_dec.sv
module hreg_addr_dec
   import hreg_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int IDX_W  = 5,
   parameter int CNT_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  cfg_ports,
   output logic              glob_hit,
   output logic              port_hit,
   output logic [IDX_W-1:0]  port_idx,
   output logic [6:0]        reg_off
);
   logic [31:0] a32;
   logic [31:0] limit;

   always_comb begin
      a32      = 32'(addr);
      limit    = PORT_BASE + (32'(cfg_ports) << PORT_SHIFT);
      glob_hit = (a32 < GLOB_LIMIT);
      port_hit = (a32 >= PORT_BASE) && (a32 < limit);
      port_idx = IDX_W'((a32 - PORT_BASE) >> PORT_SHIFT);
      reg_off  = a32[6:0];
   end
endmodule

// File: rtl/hreg_port_bank.sv
module hreg_port_bank
   import hreg_pkg::*;
#(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              wr_en,
   input  logic [6:0]        off,
   input  logic [31:0]       wdata,
   input  logic [STAT_W-1:0] evt,
   output logic [31:0]       rd_word,
   output logic              hit
);
   logic [STAT_W-1:0] stat_q, mask_q;
   logic [31:0]       scr_q;
   logic [STAT_W-1:0] clr_bits;

   assign clr_bits = (wr_en && off == P_STAT) ? wdata[STAT_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
         scr_q  <= '0;
      end else if (!active) begin
         stat_q <= '0;
         mask_q <= '0;
         scr_q  <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_bits) | evt;
         if (wr_en && off == P_MASK) mask_q <= wdata[STAT_W-1:0];
         if (wr_en && off == P_SCR)  scr_q  <= wdata;
      end
   end

   always_comb begin
      case (off)
         P_STAT:  rd_word = 32'(stat_q);
         P_MASK:  rd_word = 32'(mask_q);
         P_SCR:   rd_word = scr_q;
         default: rd_word = '0;
      endcase
   end

   assign hit = |(stat_q & mask_q);

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && wr_en && off == P_STAT) |=> ((stat_q & $past(wdata[STAT_W-1:0] & ~evt)) == '0)); // R5
   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))); // R5
   AST_IDLE_PORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (stat_q == '0 && mask_q == '0 && !hit)); // R10
endmodule

// File: rtl/hreg_irq_agg.sv
module hreg_irq_agg #(
   parameter int MAX_PORTS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MAX_PORTS-1:0] hit_v,
   input  logic [MAX_PORTS-1:0] active_v,
   input  logic                 ien,
   output logic [MAX_PORTS-1:0] pend_q,
   output logic                 irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= hit_v & active_v;
   end

   assign irq = ien && (pend_q != '0);
endmodule

// File: rtl/mp_hostreg.sv
module mp_hostreg
   import hreg_pkg::*;
#(
   parameter int MAX_PORTS = 32,
   parameter int STAT_W    = 8,
   parameter int ADDR_W    = 13,
   localparam int IDX_W    = (MAX_PORTS > 1) ? $clog2(MAX_PORTS) : 1,
   localparam int CNT_W    = $clog2(MAX_PORTS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CNT_W-1:0]            cfg_ports,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [31:0]                 req_wdata,
   output logic                        rsp_valid,
   output logic [31:0]                 rsp_rdata,
   input  logic [MAX_PORTS*STAT_W-1:0] port_evt,
   output logic [MAX_PORTS-1:0]        irq_pending,
   output logic                        irq_out
);
   localparam longint SPAN_END = 64'(PORT_BASE) + 64'(MAX_PORTS) * 64'h80;

   if (MAX_PORTS < 1 || MAX_PORTS > 32) begin : g_bad_ports
      $error("MAX_PORTS must lie in 1..32");
   end
   if (STAT_W < 1 || STAT_W > 32) begin : g_bad_stat
      $error("STAT_W must lie in 1..32");
   end
   if (SPAN_END > (64'd1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the port region");
   end

   logic             glob_hit, port_hit;
   logic [IDX_W-1:0] port_idx;
   logic [6:0]       reg_off;
   logic             ien_q;
   logic [MAX_PORTS-1:0] hit_v, active_v, pend_q;
   logic [31:0]      port_rd [MAX_PORTS];
   logic [31:0]      rd_mux;
   logic             idx_ok;
   logic             rd_req, wr_req;

   assign rd_req = req_valid && !req_write;
   assign wr_req = req_valid && req_write;
   assign idx_ok = (32'(port_idx) < MAX_PORTS);

   hreg_addr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dec (
      .addr(req_addr), .cfg_ports(cfg_ports),
      .glob_hit(glob_hit), .port_hit(port_hit),
      .port_idx(port_idx), .reg_off(reg_off)
   );

   for (genvar i = 0; i < MAX_PORTS; i++) begin : g_port
      logic sel_wr;
      assign active_v[i] = (32'(cfg_ports) > i);
      assign sel_wr = wr_req && port_hit && idx_ok && (32'(port_idx) == i);
      hreg_port_bank #(.STAT_W(STAT_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .active(active_v[i]),
         .wr_en(sel_wr), .off(reg_off), .wdata(req_wdata),
         .evt(port_evt[i*STAT_W +: STAT_W]),
         .rd_word(port_rd[i]), .hit(hit_v[i])
      );
   end

   hreg_irq_agg #(.MAX_PORTS(MAX_PORTS)) u_agg (
      .clk(clk), .rst_n(rst_n), .hit_v(hit_v), .active_v(active_v),
      .ien(ien_q), .pend_q(pend_q), .irq(irq_out)
   );
   assign irq_pending = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ien_q <= 1'b0;
      else if (wr_req && glob_hit && reg_off == G_HCTL) ien_q <= req_wdata[IEN_BIT];
   end

   always_comb begin
      rd_mux = '0;
      if (glob_hit) begin
         case (reg_off)
            G_CAP:   rd_mux = cap_word(int'(cfg_ports));
            G_HCTL:  rd_mux = 32'(ien_q) << IEN_BIT;
            G_PEND:  rd_mux = 32'(pend_q);
            G_PIMP:  rd_mux = pimp_word(int'(cfg_ports));
            G_VER:   rd_mux = VER_CODE;
            default: rd_mux = '0;
         endcase
      end else if (port_hit && idx_ok) begin
         rd_mux = port_rd[port_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_req;
         if (rd_req) rsp_rdata <= rd_mux;
      end
   end

   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid); // R8
   AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(rd_req)); // R8
   AST_IEN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && req_addr == ADDR_W'(4) && !req_wdata[IEN_BIT]) |=> !irq_out); // R7
   AST_CFG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ports >= CNT_W'(1)) && (32'(cfg_ports) <= MAX_PORTS)); // R3
endmodule

// File: tb/mp_hostreg_tb.sv
module mp_hostreg_tb;
   localparam int NP = 32;
   localparam int SW = 8;
   localparam int AW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] cfg_ports = 6'd4;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic rsp_valid;
   logic [31:0] rsp_rdata;
   logic [NP*SW-1:0] port_evt = '0;
   logic [NP-1:0] irq_pending;
   logic irq_out;

   int n_chk = 0, n_bad = 0, cyc = 0;

   logic [SW-1:0] m_st [NP];
   logic [SW-1:0] m_mk [NP];
   logic [31:0]   m_sc [NP];
   logic [NP-1:0] m_pend;
   logic          m_ien;

   always #4 clk = ~clk;

   mp_hostreg #(.MAX_PORTS(NP), .STAT_W(SW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_ports(cfg_ports),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .port_evt(port_evt), .irq_pending(irq_pending), .irq_out(irq_out)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] exp_cap(input int n);
      return 32'h4014_1F00 | 32'(n - 1);
   endfunction

   function automatic logic [31:0] exp_pimp(input int n);
      if (n >= 32) return 32'hFFFF_FFFF;
      return (32'd1 << n) - 32'd1;
   endfunction

   function automatic logic [31:0] model_read(input int a);
      int n, p, o;
      n = int'(cfg_ports);
      if (a < 32'h20) begin
         case (a)
            'h00: return exp_cap(n);
            'h04: return {30'd0, m_ien, 1'b0};
            'h08: return m_pend;
            'h0C: return exp_pimp(n);
            'h10: return 32'h0001_0000;
            default: return 32'h0;
         endcase
      end
      if (a >= 'h100 && a < 'h100 + n * 'h80) begin
         p = (a - 'h100) >> 7;
         o = a & 'h7F;
         case (o)
            'h00: return 32'(m_st[p]);
            'h04: return 32'(m_mk[p]);
            'h08: return m_sc[p];
            default: return 32'h0;
         endcase
      end
      return 32'h0;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < NP; i++) begin
         m_st[i] = '0; m_mk[i] = '0; m_sc[i] = '0;
      end
      m_pend = '0;
      m_ien  = 1'b0;
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic step(input bit v, input bit w, input int a, input logic [31:0] d,
                       input logic [NP*SW-1:0] ev, input string tag);
      logic [31:0] exp_rd;
      bit exp_rv;
      logic [NP-1:0] nxt_pend;
      int n, p, o;
      req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = d; port_evt = ev;
      n = int'(cfg_ports);
      exp_rv = v && !w;
      exp_rd = model_read(a);
      for (int i = 0; i < NP; i++)
         nxt_pend[i] = (i < n) && ((m_st[i] & m_mk[i]) != '0);
      @(posedge clk);
      // model update for this edge
      if (v && w && a == 'h04) m_ien = d[1];
      for (int i = 0; i < NP; i++) begin
         if (i >= n) begin
            m_st[i] = '0; m_mk[i] = '0; m_sc[i] = '0;
         end else begin
            logic [SW-1:0] clr;
            clr = '0;
            if (v && w && a >= 'h100 && a < 'h100 + n * 'h80) begin
               p = (a - 'h100) >> 7;
               o = a & 'h7F;
               if (p == i) begin
                  if (o == 'h00) clr = d[SW-1:0];
                  if (o == 'h04) m_mk[i] = d[SW-1:0];
                  if (o == 'h08) m_sc[i] = d;
               end
            end
            m_st[i] = (m_st[i] & ~clr) | ev[i*SW +: SW];
         end
      end
      m_pend = nxt_pend;
      @(negedge clk);
      check(rsp_valid == exp_rv, "R8 rsp_valid", 32'(rsp_valid), 32'(exp_rv));
      if (exp_rv) check(rsp_rdata == exp_rd, tag, rsp_rdata, exp_rd);
      check(irq_pending == m_pend, "R6 pending", irq_pending, m_pend);
      check(irq_out == (m_ien && m_pend != '0), "R7 irq_out", 32'(irq_out), 32'(m_ien && m_pend != '0));
      req_valid = 1'b0; port_evt = '0;
   endtask

   task automatic rd(input int a, input string tag);
      step(1'b1, 1'b0, a, 32'h0, '0, tag);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      step(1'b1, 1'b1, a, d, '0, "R4 write");
   endtask

   task automatic idle_evt(input logic [NP*SW-1:0] ev);
      step(1'b0, 1'b0, 0, 32'h0, ev, "R5 event");
   endtask

   initial begin : watchdog
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog expired actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      logic [NP*SW-1:0] ev;
      int a, kind;
      void'($urandom(32'd20240611));
      model_clear();
      @(negedge clk);
      @(negedge clk);
      // R9 reset state
      check(rsp_valid == 1'b0, "R9 reset rsp_valid", 32'(rsp_valid), 0);
      check(irq_pending == '0, "R9 reset pending", irq_pending, 0);
      check(irq_out == 1'b0, "R9 reset irq", 32'(irq_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 capability, implemented mask, version across port counts
      cfg_ports = 6'd6;  rd('h00, "R1 cap 6 ports"); rd('h0C, "R2 pimp 6"); rd('h10, "R2 version");
      check(exp_cap(6) == 32'h4014_1F05, "R1 cap constant", exp_cap(6), 32'h4014_1F05);
      cfg_ports = 6'd32; rd('h00, "R1 cap 32 ports"); rd('h0C, "R2 pimp 32");
      cfg_ports = 6'd1;  rd('h00, "R1 cap 1 port");   rd('h0C, "R2 pimp 1");
      // R4 writes to read-only globals ignored
      wr('h00, 32'hFFFF_FFFF); wr('h0C, 32'h0); wr('h10, 32'h0);
      rd('h00, "R4 cap after write"); rd('h0C, "R4 pimp after write"); rd('h10, "R4 ver after write");

      // R3 window decode and R4 boundary
      cfg_ports = 6'd5;
      wr('h100 + 4*'h80 + 8, 32'hCAFE_0004);
      rd('h100 + 4*'h80 + 8, "R3 last live port scratch");
      wr('h100 + 5*'h80 + 8, 32'h1234_5678);
      rd('h100 + 5*'h80 + 8, "R4 first dead port reads zero");
      wr('h100 + 0*'h80 + 'h0C, 32'hFFFF_FFFF);
      rd('h100 + 'h0C, "R4 unlisted port offset");
      rd('h14, "R4 global hole"); rd('h80, "R4 gap below ports");

      // R5 W1C and event priority
      idle_evt(NP*SW'(8'hF0) << (2*SW));
      rd('h100 + 2*'h80, "R5 status after event");
      wr('h100 + 2*'h80, 32'h0000_0030);
      rd('h100 + 2*'h80, "R5 W1C result");
      ev = '0; ev[2*SW +: SW] = 8'h40;
      step(1'b1, 1'b1, 'h100 + 2*'h80, 32'h0000_00C0, ev, "R5 set beats clear");
      rd('h100 + 2*'h80, "R5 set wins");

      // R6 / R7 pending and interrupt line
      wr('h100 + 2*'h80 + 4, 32'h0000_0040);
      idle_evt('0);
      rd('h08, "R6 pending read");
      wr('h04, 32'h0000_0002);
      rd('h04, "R7 enable readback");
      idle_evt('0);
      wr('h04, 32'h0);
      idle_evt('0);

      // R10 shrinking the port count clears dead ports
      cfg_ports = 6'd2;
      idle_evt('1);
      cfg_ports = 6'd5;
      rd('h100 + 2*'h80 + 4, "R10 mask cleared on shrink");
      rd('h100 + 4*'h80 + 8, "R10 scratch cleared on shrink");

      // random mix
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 99) == 0) cfg_ports = 6'($urandom_range(1, NP));
         ev = '0;
         for (int i = 0; i < NP; i++)
            if ($urandom_range(0, 7) == 0) ev[i*SW +: SW] = SW'($urandom);
         kind = $urandom_range(0, 9);
         case ($urandom_range(0, 3))
            0: a = 4 * $urandom_range(0, 7);
            1: a = 'h100 + $urandom_range(0, NP - 1) * 'h80 + 4 * $urandom_range(0, 3);
            2: a = 4 * $urandom_range(0, 'h7FF);
            default: a = 'h100 + $urandom_range(0, 7) * 'h80 + 4 * $urandom_range(0, 2);
         endcase
         if (kind < 4)      step(1'b1, 1'b0, a, 32'h0, ev, "R3 random read");
         else if (kind < 8) step(1'b1, 1'b1, a, $urandom, ev, "R4 random write");
         else               step(1'b0, 1'b0, 0, 32'h0, ev, "R6 random idle");
      end

      // R9 reset in mid-run
      wr('h04, 32'h2);
      rst_n = 1'b0;
      model_clear();
      @(negedge clk);
      check(irq_pending == '0, "R9 pending after reset", irq_pending, 0);
      check(irq_out == 1'b0, "R9 irq after reset", 32'(irq_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd('h04, "R9 enable cleared");
      rd('h100 + 'h04, "R9 port mask cleared");
      rd('h100 + 'h08, "R9 port scratch cleared");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule